// File: doc/BRIEF.md
# Transmit FIFO with Rewindable Frame Start

This block is a synchronous transmit queue placed between a DMA-style producer and a transmit protocol engine. Each entry carries a data word plus two tag bits that mark the first and last word of a frame. The engine pops words through a read port. The producer pushes words through a write port that has a full flag. While the engine is sending, the queue can keep the first words of the current frame reserved. If a retryable error occurs early in the frame, the engine can then replay the frame from its first word without the producer fetching the data again.

Reservation is switched on by a hold enable input. When the engine reads a start-tagged word, the queue saves that word's position. Storage from that position onward stays allocated until a programmed number of words of the frame has been read, or until the frame's last word has been read. During that window, a rewind request moves the read position back to the saved first word. Outside the window a rewind request does nothing. A separate start level tells the engine when enough words are queued to begin a frame. Lost writes and reads of an empty queue inside a frame are reported as one-cycle pulses, which a status block can collect.

Top module: `txq_rewind_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `rd_valid`, `ovf_pulse` and `unf_pulse` are 0, and `start_ok` is 0 whenever `cfg_start_lvl` is non-zero.
- R2: Words come out in the order they were accepted. Each accepted read (`rd_en` high, `empty` low, no effective rewind) gives `rd_valid` high one cycle later, with that word's data, start tag (`rd_sof`) and end tag (`rd_eof`).
- R3: A write while `full` is high is dropped, and the stored contents do not change. `ovf_pulse` is high for exactly the following cycle.
- R4: A read request while `empty` is high, after a start-tagged word has been read and before that frame's end-tagged word has been read, raises `unf_pulse` for the following cycle. The same request between frames raises no pulse.
- R5: `start_ok` is high while a frame is being read. Between frames it is high exactly when the number of unread words is at least `cfg_start_lvl`.
- R6: Reservation starts when `cfg_hold_en` is 1, `cfg_keep_cnt` is greater than 1, and a start-tagged word without an end tag is read. While it lasts, `full` is measured from the frame's first word, so reserved words are never overwritten. Reservation ends in the cycle after the `cfg_keep_cnt`-th word of the frame is read, and `full` is then measured from the read position.
- R7: A `rewind` pulse during reservation moves the read position back to the frame's first word. The following reads return the frame again from its start-tagged word.
- R8: A `rewind` pulse after reservation has ended has no effect: reads continue with the next unread word.
- R9: With `cfg_hold_en` at 0 the queue acts as a plain FIFO. Each read frees its word at once, and `rewind` has no effect.
- R10: A frame of at most `cfg_keep_cnt` words stays rewindable until its end-tagged word is read. After that, `rewind` has no effect.
- R11: When `rewind` takes effect in the same cycle as `rd_en`, the read is not performed and `rd_valid` stays 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hold_en | input | 1 | Enables reservation of the frame start |
| cfg_keep_cnt | input | ADDR_W+1 | Number of frame words read before reserved storage is released |
| cfg_start_lvl | input | ADDR_W+1 | Unread word count needed before a frame may start |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| wr_sof | input | 1 | Tag: word is the first of a frame |
| wr_eof | input | 1 | Tag: word is the last of a frame |
| full | output | 1 | No free storage; writes are dropped |
| rd_en | input | 1 | Read request |
| rewind | input | 1 | Replay the current frame from its first word |
| rd_valid | output | 1 | Read result valid (one cycle after accept) |
| rd_data | output | DATA_W | Read data |
| rd_sof | output | 1 | Start tag of the word read |
| rd_eof | output | 1 | End tag of the word read |
| empty | output | 1 | No unread words |
| start_ok | output | 1 | Enough words queued to begin or continue a frame |
| ovf_pulse | output | 1 | One-cycle pulse: a write was dropped |
| unf_pulse | output | 1 | One-cycle pulse: read of an empty queue inside a frame |

## Verification
The hardest case to reach is a queue that is completely full while reservation is active. In that state some words have already been read, yet `full` must stay high, and a rewind must still bring back the oldest word. The stimulus fills the queue to its depth with a single frame and reads fewer words than the keep count. It then writes one more word, which must be lost, and rewinds. Next it reads exactly the keep count, so `full` drops at the release point, and issues a second rewind that must be ignored. A short frame, a rewind issued in the same cycle as a read, and a read of an empty queue inside a frame exercise the other edges of the window.

// File: rtl/txq_pkg.sv
package txq_pkg;

  // Frame tracking state of the read side
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,  // between frames
    FR_HELD = 2'd1,  // inside a frame, start words reserved
    FR_OPEN = 2'd2   // inside a frame, reservation released
  } frame_st_t;

  localparam int TAG_W = 2;  // {sof, eof}

endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DATA_W = 8,
  parameter int AW     = 4
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [txq_pkg::TAG_W-1:0] wtag,
  input  logic                     re,
  input  logic [AW-1:0]            raddr,
  output logic [DATA_W-1:0]        rdata,
  output logic [txq_pkg::TAG_W-1:0] head_tag
);
  localparam int DEPTH = 1 << AW;

  // Data words: write port plus registered read port, fits block RAM
  logic [DATA_W-1:0] data_mem [DEPTH];
  // Tag bits: small array read without a register so control sees the head
  logic [txq_pkg::TAG_W-1:0] tag_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) data_mem[waddr] <= wdata;
    if (re) rdata <= data_mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (we) tag_mem[waddr] <= wtag;
  end

  assign head_tag = tag_mem[raddr];

endmodule

// File: rtl/txq_wrctl.sv
module txq_wrctl #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [AW:0] free_ptr,
  output logic [AW:0] wr_ptr,
  output logic        wr_accept,
  output logic        full,
  output logic        ovf_pulse
);
  logic [AW:0] wr_ptr_q;
  logic        ovf_q;

  // Full when the write pointer is one lap ahead of the oldest held word
  assign full      = (wr_ptr_q[AW] != free_ptr[AW]) &&
                     (wr_ptr_q[AW-1:0] == free_ptr[AW-1:0]);
  assign wr_accept = wr_en && !full;
  assign wr_ptr    = wr_ptr_q;
  assign ovf_pulse = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      ovf_q <= wr_en && full;
      if (wr_accept) wr_ptr_q <= wr_ptr_q + 1'b1;
    end
  end

  // R3
  drop_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> (wr_ptr_q == $past(wr_ptr_q)));

  // R3
  ovf_follows_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> $past(wr_en && full));

endmodule

// File: rtl/txq_rdctl.sv
module txq_rdctl
  import txq_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hold_en,
  input  logic [AW:0] keep_cnt,
  input  logic [AW:0] start_lvl,
  input  logic        rd_en,
  input  logic        rewind,
  input  logic [AW:0] wr_ptr,
  input  logic        head_sof,
  input  logic        head_eof,
  output logic        rd_accept,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0] free_ptr,
  output logic        empty,
  output logic        start_ok,
  output logic        unf_pulse
);
  localparam int LVL_W = AW + 1;

  logic [AW:0]    rd_ptr_q, base_q, live;
  logic [LVL_W-1:0] sent_q, sent_nx;
  frame_st_t      st_q;
  logic           unf_q, do_rewind, arm;

  assign live      = wr_ptr - rd_ptr_q;
  assign empty     = (live == '0);
  assign do_rewind = rewind && (st_q == FR_HELD);
  assign rd_accept = rd_en && !empty && !do_rewind;
  assign rd_addr   = rd_ptr_q[AW-1:0];
  assign free_ptr  = (st_q == FR_HELD) ? base_q : rd_ptr_q;
  assign start_ok  = (st_q != FR_IDLE) || (live >= start_lvl);
  assign unf_pulse = unf_q;
  assign arm       = hold_en && (keep_cnt > LVL_W'(1));
  assign sent_nx   = sent_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr_q <= '0;
      base_q   <= '0;
      st_q     <= FR_IDLE;
      sent_q   <= '0;
      unf_q    <= 1'b0;
    end else begin
      unf_q <= rd_en && empty && !do_rewind && (st_q != FR_IDLE);
      if (do_rewind) begin
        rd_ptr_q <= base_q;
        st_q     <= FR_IDLE;
        sent_q   <= '0;
      end else if (rd_accept) begin
        rd_ptr_q <= rd_ptr_q + 1'b1;
        if (head_sof) begin
          if (head_eof) begin
            st_q <= FR_IDLE;
          end else if (arm) begin
            st_q   <= FR_HELD;
            base_q <= rd_ptr_q;
            sent_q <= LVL_W'(1);
          end else begin
            st_q <= FR_OPEN;
          end
        end else if (st_q != FR_IDLE) begin
          if (head_eof) begin
            st_q <= FR_IDLE;
          end else if (st_q == FR_HELD) begin
            sent_q <= sent_nx;
            if (sent_nx >= keep_cnt) st_q <= FR_OPEN;
          end
        end
      end
    end
  end

  // R7
  rewind_restores_chk: assert property (@(posedge clk) disable iff (rst)
    (rewind && st_q == FR_HELD) |=> (rd_ptr_q == $past(base_q)));

  // R8
  rewind_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (rewind && st_q != FR_HELD && !rd_en) |=> (rd_ptr_q == $past(rd_ptr_q)));

  // R4
  unf_only_empty_chk: assert property (@(posedge clk) disable iff (rst)
    unf_q |-> $past(empty && rd_en));

  // R11
  rewind_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rewind && st_q == FR_HELD) |-> !rd_accept);

endmodule

// File: rtl/txq_rewind_fifo.sv
module txq_rewind_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_hold_en,
  input  logic [ADDR_W:0]   cfg_keep_cnt,
  input  logic [ADDR_W:0]   cfg_start_lvl,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sof,
  input  logic              wr_eof,
  output logic              full,
  input  logic              rd_en,
  input  logic              rewind,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sof,
  output logic              rd_eof,
  output logic              empty,
  output logic              start_ok,
  output logic              ovf_pulse,
  output logic              unf_pulse
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LVL_W = ADDR_W + 1;

  logic [ADDR_W:0]   wr_ptr, free_ptr, occ;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_accept, rd_accept;
  logic [txq_pkg::TAG_W-1:0] head_tag;
  logic              valid_q, sof_q, eof_q;

  txq_wrctl #(.AW(ADDR_W)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .free_ptr  (free_ptr),
    .wr_ptr    (wr_ptr),
    .wr_accept (wr_accept),
    .full      (full),
    .ovf_pulse (ovf_pulse)
  );

  txq_rdctl #(.AW(ADDR_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .hold_en   (cfg_hold_en),
    .keep_cnt  (cfg_keep_cnt),
    .start_lvl (cfg_start_lvl),
    .rd_en     (rd_en),
    .rewind    (rewind),
    .wr_ptr    (wr_ptr),
    .head_sof  (head_tag[1]),
    .head_eof  (head_tag[0]),
    .rd_accept (rd_accept),
    .rd_addr   (rd_addr),
    .free_ptr  (free_ptr),
    .empty     (empty),
    .start_ok  (start_ok),
    .unf_pulse (unf_pulse)
  );

  txq_store #(.DATA_W(DATA_W), .AW(ADDR_W)) u_mem (
    .clk      (clk),
    .we       (wr_accept),
    .waddr    (wr_ptr[ADDR_W-1:0]),
    .wdata    (wr_data),
    .wtag     ({wr_sof, wr_eof}),
    .re       (rd_accept),
    .raddr    (rd_addr),
    .rdata    (rd_data),
    .head_tag (head_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      sof_q   <= 1'b0;
      eof_q   <= 1'b0;
    end else begin
      valid_q <= rd_accept;
      if (rd_accept) begin
        sof_q <= head_tag[1];
        eof_q <= head_tag[0];
      end
    end
  end

  assign rd_valid = valid_q;
  assign rd_sof   = sof_q;
  assign rd_eof   = eof_q;
  assign occ      = wr_ptr - free_ptr;

  // R6
  held_capacity_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= LVL_W'(DEPTH));

  // R2
  valid_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en && !empty));

endmodule

// File: tb/sim_txq_rewind_fifo.sv
module sim_txq_rewind_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_hold_en = 1'b0;
  logic [AW:0] cfg_keep_cnt = 5'd4;
  logic [AW:0] cfg_start_lvl = 5'd3;
  logic wr_en = 1'b0, wr_sof = 1'b0, wr_eof = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic rd_en = 1'b0, rewind = 1'b0;
  logic full, rd_valid, rd_sof, rd_eof, empty, start_ok, ovf_pulse, unf_pulse;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [DW+1:0] exp_q[$];
  logic [DW+1:0] hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  txq_rewind_fifo #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .cfg_hold_en(cfg_hold_en), .cfg_keep_cnt(cfg_keep_cnt),
    .cfg_start_lvl(cfg_start_lvl), .wr_en(wr_en), .wr_data(wr_data), .wr_sof(wr_sof),
    .wr_eof(wr_eof), .full(full), .rd_en(rd_en), .rewind(rewind), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_sof(rd_sof), .rd_eof(rd_eof), .empty(empty),
    .start_ok(start_ok), .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every valid read result (R2)
  always @(negedge clk) begin : monitor
    logic [DW+1:0] got, want;
    if (!rst && rd_valid) begin
      got = {rd_sof, rd_eof, rd_data};
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected word", 32'(got), 32'h0);
      end else begin
        want = exp_q.pop_front();
        check(got == want, "R2 word order", 32'(got), 32'(want));
      end
      if (rd_sof) hist.delete();
      hist.push_back(got);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input bit s, input bit e, input logic [DW-1:0] d, input bit kept);
    if (kept) exp_q.push_back({s, e, d});
    wr_en = 1'b1; wr_sof = s; wr_eof = e; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0;
  endtask

  task automatic pull(input int n);
    rd_en = 1'b1;
    repeat (n) @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_rewind();
    rewind = 1'b1;
    @(negedge clk);
    rewind = 1'b0;
  endtask

  // Expected effect of a rewind inside the window: frame words return (R7)
  task automatic replay();
    for (int i = hist.size() - 1; i >= 0; i--) exp_q.push_front(hist[i]);
    hist.delete();
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check(empty == 1'b1, "R1 empty", 32'(empty), 32'h1);
    check(full == 1'b0, "R1 full", 32'(full), 32'h0);
    check(start_ok == 1'b0, "R1 start_ok", 32'(start_ok), 32'h0);
    check(rd_valid == 1'b0 && ovf_pulse == 1'b0 && unf_pulse == 1'b0, "R1 pulses",
          32'({rd_valid, ovf_pulse, unf_pulse}), 32'h0);

    // Plain mode, start level and ignored rewind: R5, R9
    cfg_hold_en = 1'b0;
    put(1, 0, 8'h10, 1);
    check(start_ok == 1'b0, "R5 below level", 32'(start_ok), 32'h0);
    put(0, 0, 8'h11, 1);
    check(start_ok == 1'b0, "R5 below level", 32'(start_ok), 32'h0);
    put(0, 0, 8'h12, 1);
    check(start_ok == 1'b1, "R5 at level", 32'(start_ok), 32'h1);
    put(0, 0, 8'h13, 1);
    put(0, 1, 8'h14, 1);
    pull(2);
    do_rewind();  // R9: no replay expected
    pull(3);
    tick(1);
    check(exp_q.size() == 0, "R9 rewind ignored", 32'(exp_q.size()), 32'h0);
    check(start_ok == 1'b0, "R5 idle and empty", 32'(start_ok), 32'h0);

    // Overflow in plain mode: R3, R9
    for (int i = 0; i < DEPTH; i++) put(i == 0, i == DEPTH - 1, 8'h80 + 8'(i), 1);
    check(full == 1'b1, "R3 full at depth", 32'(full), 32'h1);
    put(0, 0, 8'hEE, 0);
    check(ovf_pulse == 1'b1, "R3 overflow pulse", 32'(ovf_pulse), 32'h1);
    tick(1);
    check(ovf_pulse == 1'b0, "R3 pulse one cycle", 32'(ovf_pulse), 32'h0);
    pull(1);
    check(full == 1'b0, "R9 read frees word", 32'(full), 32'h0);
    pull(DEPTH - 1);
    tick(1);
    check(empty == 1'b1 && exp_q.size() == 0, "R3 dropped word absent",
          32'(exp_q.size()), 32'h0);

    // Retention window on a full queue: R6, R7, R8
    cfg_hold_en = 1'b1;
    cfg_keep_cnt = 5'd4;
    for (int i = 0; i < DEPTH; i++) put(i == 0, i == DEPTH - 1, 8'h20 + 8'(i), 1);
    pull(3);
    check(full == 1'b1, "R6 held words keep full", 32'(full), 32'h1);
    put(0, 0, 8'hEE, 0);
    check(ovf_pulse == 1'b1, "R6 reserved word not overwritten", 32'(ovf_pulse), 32'h1);
    do_rewind();
    replay();
    check(empty == 1'b0, "R7 words back after rewind", 32'(empty), 32'h0);
    pull(4);
    check(full == 1'b0, "R6 release at keep count", 32'(full), 32'h1 ^ 32'h1);
    do_rewind();  // R8: ignored, no replay
    pull(DEPTH - 4);
    tick(1);
    check(empty == 1'b1 && exp_q.size() == 0, "R8 rewind after window ignored",
          32'(exp_q.size()), 32'h0);

    // Short frame and rewind colliding with a read: R10, R11
    put(1, 0, 8'h40, 1);
    put(0, 1, 8'h41, 1);
    pull(1);
    rd_en = 1'b1; rewind = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; rewind = 1'b0;
    check(rd_valid == 1'b0, "R11 read blocked by rewind", 32'(rd_valid), 32'h0);
    replay();  // R10 short frame still rewindable before its end
    pull(2);
    do_rewind();  // R10: after end word, ignored
    put(1, 1, 8'h50, 1);
    pull(1);
    tick(1);
    check(exp_q.size() == 0, "R10 rewind after end ignored", 32'(exp_q.size()), 32'h0);

    // Underflow: R4
    cfg_hold_en = 1'b0;
    pull(1);
    check(unf_pulse == 1'b0, "R4 no pulse between frames", 32'(unf_pulse), 32'h0);
    put(1, 0, 8'h60, 1);
    pull(1);
    pull(1);
    check(unf_pulse == 1'b1, "R4 pulse inside frame", 32'(unf_pulse), 32'h1);
    tick(1);
    check(unf_pulse == 1'b0, "R4 pulse one cycle", 32'(unf_pulse), 32'h0);
    put(0, 1, 8'h61, 1);
    pull(1);
    tick(2);
    check(exp_q.size() == 0 && empty == 1'b1, "R2 all words delivered",
          32'(exp_q.size()), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule